// File: doc/BRIEF.md
# Indirect Internal-Bus Access Bridge

This block gives a host a narrow path into a 32-bit internal bus. The host sees four 64-bit registers: control, reset, status and data. It reaches the internal bus only through them. A host write to the control register starts one internal transaction. The target address, the transfer size and the direction are all taken from the written word. The bridge then drives a request on the internal port and holds it until the port acknowledges.

The result of the transaction is placed in the status register. For a read, the status word carries a done flag and the returned data. For a write, it carries only the done flag. Reading the status register returns its value and clears it in the same access, so software polls status until the done flag appears. Write data for an internal write is staged beforehand in the data register.

The host port accepts only aligned 8-byte accesses. Any other access is answered with an error and changes nothing.

Top module: `ibus_bridge`

## Requirements
- R1: A host access is valid only when `host_size_i` equals 8 and `host_addr_i[2:0]` is zero. An invalid access is acknowledged one cycle later with `host_err_o` high and `host_rdata_o` zero, and it changes no register.
- R2: The register is selected by `host_addr_i[4:3]`: 0 is control, 1 is reset, 2 is status and 3 is data. A valid control write when the bridge is idle raises `bus_req_o` in the next cycle. The request carries `bus_addr_o` = word[31:0], `bus_size_o` = word[59:56], and `bus_we_o` high when word[48] is 0 (word[48] = 1 means read). All request outputs stay stable until `bus_ack_i`.
- R3: When a read completes with `bus_err_i` low, the status register becomes bit 11 set plus `bus_rdata_i` placed in bits 57:26. All other bits are zero.
- R4: When a read completes with `bus_err_i` high, the status register becomes bit 11 set plus ones in bits 57:26.
- R5: An internal write drives `bus_wdata_o` with the data register as it was at launch. Bits 31:24 hold the byte for the lowest address. After completion, status is exactly bit 11, whatever the value of `bus_err_i`.
- R6: A valid status read returns the current status in `host_rdata_o` one cycle later and clears status to zero.
- R7: A valid data write stores `host_wdata_i[63:32]`. A data read returns the stored value in bits 63:32, with bits 31:0 zero.
- R8: Reads of the control and reset registers return zero. Writes to the reset and status registers have no effect.
- R9: While a request is outstanding, status reads return zero, and a control write is ignored.
- R10: After reset there is no request, no host acknowledge, status is zero and the data register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_req_i | input | 1 | Host access strobe, one cycle per access |
| host_we_i | input | 1 | Host access is a write |
| host_addr_i | input | 5 | Host byte address within the window |
| host_size_i | input | 4 | Host access size in bytes |
| host_wdata_i | input | 64 | Host write data |
| host_ack_o | output | 1 | Access acknowledge, one cycle after the strobe |
| host_err_o | output | 1 | Access rejected (bad size or alignment) |
| host_rdata_o | output | 64 | Host read data, valid with the acknowledge |
| bus_req_o | output | 1 | Internal request, held until acknowledge |
| bus_we_o | output | 1 | Internal request is a write |
| bus_addr_o | output | 32 | Internal address |
| bus_size_o | output | 4 | Internal transfer size |
| bus_wdata_o | output | 32 | Internal write data, lowest-address byte in bits 31:24 |
| bus_ack_i | input | 1 | Internal completion pulse |
| bus_err_i | input | 1 | Internal error, sampled with the acknowledge |
| bus_rdata_i | input | 32 | Internal read data, sampled with the acknowledge |

## Verification
The bench targets several corner cases, each paired with the faulty behaviour it would expose:

- A write that completes with the error flag set must still leave only the done flag in status. A design that folded the bus error into the status word would show extra bits there.
- A read error must fill the data field with ones. A design that latched the bus data instead would not.
- A second control write while a request is outstanding must not move the address. A design that relaunched would change it.
- Status reads during a pending request must return zero.
- A second status read must return zero. A design missing clear-on-read would repeat the old value.
- Misaligned or short accesses and writes to the reset and status registers must leave the data and status registers untouched. A design that ignored the size check or decoded those writes would corrupt them.

// File: rtl/ibb_pkg.sv
package ibb_pkg;
  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_RST  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_DATA = 2'd3
  } reg_sel_e;

  localparam int unsigned HOST_DW    = 64;
  localparam int unsigned HOST_AW    = 5;
  localparam int unsigned HOST_BYTES = HOST_DW / 8;
  localparam int unsigned BUS_AW     = 32;
  localparam int unsigned BUS_DW     = 32;
  localparam int unsigned SZ_W       = 4;

  localparam int unsigned CTL_RD_BIT = 48;
  localparam int unsigned CTL_SZ_LO  = 56;
  localparam int unsigned DONE_BIT   = 11;
  localparam int unsigned RD_LO      = 26;
  localparam int unsigned DATA_LO    = HOST_DW - BUS_DW;

  localparam logic [HOST_DW-1:0] DONE_MASK = 64'd1 << DONE_BIT;

  typedef struct packed {
    logic              we;
    logic [SZ_W-1:0]   size;
    logic [BUS_AW-1:0] addr;
  } bus_op_t;
endpackage

// File: rtl/ibb_host_regs.sv
module ibb_host_regs
  import ibb_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                host_req_i,
  input  logic                host_we_i,
  input  logic [HOST_AW-1:0]  host_addr_i,
  input  logic [SZ_W-1:0]     host_size_i,
  input  logic [HOST_DW-1:0]  host_wdata_i,
  output logic                host_ack_o,
  output logic                host_err_o,
  output logic [HOST_DW-1:0]  host_rdata_o,
  input  logic                busy_i,
  input  logic [HOST_DW-1:0]  status_i,
  output logic                launch_o,
  output bus_op_t             op_o,
  output logic                stat_rd_o,
  output logic [BUS_DW-1:0]   data_o
);
  localparam int unsigned OFS_W = $clog2(HOST_BYTES);

  logic              ok;
  reg_sel_e          sel;
  logic [BUS_DW-1:0] data_q;
  logic              ack_q, err_q;
  logic [HOST_DW-1:0] rdata_q;

  assign ok  = host_req_i && (host_size_i == SZ_W'(HOST_BYTES))
               && (host_addr_i[OFS_W-1:0] == '0);
  assign sel = reg_sel_e'(host_addr_i[OFS_W+1:OFS_W]);

  assign launch_o  = ok && host_we_i && (sel == SEL_CTL) && !busy_i;
  assign stat_rd_o = ok && !host_we_i && (sel == SEL_STAT);
  assign op_o.we   = !host_wdata_i[CTL_RD_BIT];
  assign op_o.size = host_wdata_i[CTL_SZ_LO +: SZ_W];
  assign op_o.addr = host_wdata_i[BUS_AW-1:0];
  assign data_o    = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      ack_q   <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q   <= host_req_i;
      err_q   <= host_req_i && !ok;
      rdata_q <= '0;
      if (ok && host_we_i && (sel == SEL_DATA))
        data_q <= host_wdata_i[HOST_DW-1:DATA_LO];
      if (ok && !host_we_i) begin
        unique case (sel)
          SEL_STAT: rdata_q <= status_i;
          SEL_DATA: rdata_q <= {data_q, {DATA_LO{1'b0}}};
          default:  rdata_q <= '0;
        endcase
      end
    end
  end

  assign host_ack_o   = ack_q;
  assign host_err_o   = err_q;
  assign host_rdata_o = rdata_q;

  AST_BAD_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_req_i && !ok |=> host_err_o && host_rdata_o == '0); // R1
  AST_ACK_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_req_i |=> host_ack_o); // R1
  AST_DATA_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ok && host_we_i) |=> $stable(data_q)); // R8
endmodule

// File: rtl/ibb_bus_master.sv
module ibb_bus_master
  import ibb_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               launch_i,
  input  bus_op_t            op_i,
  input  logic               stat_rd_i,
  input  logic [BUS_DW-1:0]  data_i,
  output logic               bus_req_o,
  output logic               bus_we_o,
  output logic [BUS_AW-1:0]  bus_addr_o,
  output logic [SZ_W-1:0]    bus_size_o,
  output logic [BUS_DW-1:0]  bus_wdata_o,
  input  logic               bus_ack_i,
  input  logic               bus_err_i,
  input  logic [BUS_DW-1:0]  bus_rdata_i,
  output logic               busy_o,
  output logic [HOST_DW-1:0] status_o
);
  logic               busy_q;
  bus_op_t            op_q;
  logic [BUS_DW-1:0]  wdata_q;
  logic [HOST_DW-1:0] status_q;
  logic [HOST_DW-1:0] rd_word;

  assign rd_word = DONE_MASK |
                   ({{(HOST_DW-BUS_DW){1'b0}}, (bus_err_i ? {BUS_DW{1'b1}} : bus_rdata_i)} << RD_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      op_q     <= '0;
      wdata_q  <= '0;
      status_q <= '0;
    end else if (launch_i) begin
      busy_q   <= 1'b1;
      op_q     <= op_i;
      wdata_q  <= data_i;
      status_q <= '0;
    end else if (busy_q && bus_ack_i) begin
      busy_q   <= 1'b0;
      status_q <= op_q.we ? DONE_MASK : rd_word;
    end else if (stat_rd_i) begin
      status_q <= '0;
    end
  end

  assign bus_req_o   = busy_q;
  assign bus_we_o    = op_q.we;
  assign bus_addr_o  = op_q.addr;
  assign bus_size_o  = op_q.size;
  assign bus_wdata_o = wdata_q;
  assign busy_o      = busy_q;
  assign status_o    = status_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_wdata_o)
      && $stable(bus_we_o)); // R2
  AST_PEND_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> status_o == '0); // R9
  AST_STAT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i && !bus_req_o |=> status_o == '0); // R6
  AST_WR_DONE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_ack_i && bus_we_o |=> status_o == DONE_MASK); // R5
  AST_RD_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_ack_i && !bus_we_o |=> status_o[DONE_BIT]
      && status_o[RD_LO-1:0] == DONE_MASK[RD_LO-1:0]); // R3
endmodule

// File: rtl/ibus_bridge.sv
module ibus_bridge
  import ibb_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                host_req_i,
  input  logic                host_we_i,
  input  logic [HOST_AW-1:0]  host_addr_i,
  input  logic [SZ_W-1:0]     host_size_i,
  input  logic [HOST_DW-1:0]  host_wdata_i,
  output logic                host_ack_o,
  output logic                host_err_o,
  output logic [HOST_DW-1:0]  host_rdata_o,
  output logic                bus_req_o,
  output logic                bus_we_o,
  output logic [BUS_AW-1:0]   bus_addr_o,
  output logic [SZ_W-1:0]     bus_size_o,
  output logic [BUS_DW-1:0]   bus_wdata_o,
  input  logic                bus_ack_i,
  input  logic                bus_err_i,
  input  logic [BUS_DW-1:0]   bus_rdata_i
);
  logic               launch, stat_rd, busy;
  bus_op_t            op;
  logic [BUS_DW-1:0]  data;
  logic [HOST_DW-1:0] status;

  ibb_host_regs u_regs (
    .clk_i, .rst_ni, .host_req_i, .host_we_i, .host_addr_i, .host_size_i,
    .host_wdata_i, .host_ack_o, .host_err_o, .host_rdata_o,
    .busy_i(busy), .status_i(status), .launch_o(launch), .op_o(op),
    .stat_rd_o(stat_rd), .data_o(data)
  );

  ibb_bus_master u_mst (
    .clk_i, .rst_ni, .launch_i(launch), .op_i(op), .stat_rd_i(stat_rd),
    .data_i(data), .bus_req_o, .bus_we_o, .bus_addr_o, .bus_size_o,
    .bus_wdata_o, .bus_ack_i, .bus_err_i, .bus_rdata_i,
    .busy_o(busy), .status_o(status)
  );

  AST_RESET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_o) |-> $past(host_req_i && host_we_i)); // R2
endmodule

// File: tb/sim_ibus_bridge.sv
module sim_ibus_bridge;
  logic clk = 0, rst_n = 0;
  logic host_req = 0, host_we = 0;
  logic [4:0] host_addr = 0;
  logic [3:0] host_size = 0;
  logic [63:0] host_wdata = 0;
  logic host_ack, host_err;
  logic [63:0] host_rdata;
  logic bus_req, bus_we;
  logic [31:0] bus_addr, bus_wdata;
  logic [3:0] bus_size;
  logic bus_ack = 0, bus_err = 0;
  logic [31:0] bus_rdata = 0;

  int checks = 0, fails = 0;
  bit run = 0, done = 0;

  always #5 clk = ~clk;

  ibus_bridge u0 (
    .clk_i(clk), .rst_ni(rst_n), .host_req_i(host_req), .host_we_i(host_we),
    .host_addr_i(host_addr), .host_size_i(host_size), .host_wdata_i(host_wdata),
    .host_ack_o(host_ack), .host_err_o(host_err), .host_rdata_o(host_rdata),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
    .bus_size_o(bus_size), .bus_wdata_o(bus_wdata), .bus_ack_i(bus_ack),
    .bus_err_i(bus_err), .bus_rdata_i(bus_rdata)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_data = 0, m_addr = 0, m_wdata = 0;
  logic [63:0] m_status = 0, e_rdata = 0;
  logic m_busy = 0, m_we = 0, e_ack = 0, e_err = 0;
  logic [3:0] m_size = 0;
  string e_tag = "R8";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_data = 0; m_addr = 0; m_wdata = 0; m_status = 0; m_busy = 0;
      m_we = 0; m_size = 0; e_ack = 0; e_err = 0; e_rdata = 0;
    end else begin
      automatic logic was_busy = m_busy;
      automatic logic good = host_req && host_size == 4'd8 && host_addr[2:0] == 0;
      automatic int sel = int'(host_addr[4:3]);
      e_ack = host_req;
      e_err = host_req && !good;
      e_rdata = 0;
      e_tag = good ? "R8" : "R1";
      if (good && host_we) begin
        if (sel == 0 && !was_busy) begin
          m_busy = 1; m_we = !host_wdata[48]; m_size = host_wdata[59:56];
          m_addr = host_wdata[31:0]; m_wdata = m_data; m_status = 0;
        end
        if (sel == 3) m_data = host_wdata[63:32];
      end
      if (good && !host_we) begin
        if (sel == 2) begin e_rdata = m_status; e_tag = "R6"; if (!was_busy) m_status = 0; end
        if (sel == 3) begin e_rdata = {m_data, 32'h0}; e_tag = "R7"; end
      end
      if (was_busy && bus_ack) begin
        m_busy = 0;
        if (m_we) m_status = 64'h800;
        else m_status = 64'h800 | ({32'h0, (bus_err ? 32'hFFFFFFFF : bus_rdata)} << 26);
      end
    end
  end

  always @(negedge clk) begin
    if (run && rst_n) begin
      chk("R1 ack", {63'h0, host_ack}, {63'h0, e_ack});
      chk("R1 err", {63'h0, host_err}, {63'h0, e_err});
      if (host_ack) chk({e_tag, " rdata"}, host_rdata, e_rdata);
      chk("R2 req", {63'h0, bus_req}, {63'h0, m_busy});
      if (bus_req) begin
        chk("R2 addr", {32'h0, bus_addr}, {32'h0, m_addr});
        chk("R2 we", {63'h0, bus_we}, {63'h0, m_we});
        chk("R2 size", {60'h0, bus_size}, {60'h0, m_size});
        if (m_we) chk("R5 wdata", {32'h0, bus_wdata}, {32'h0, m_wdata});
      end
    end
  end

  logic [63:0] rd;
  logic er;
  task automatic host(input bit we, input logic [4:0] a, input logic [63:0] w,
                      input logic [3:0] sz = 4'd8);
    host_req = 1; host_we = we; host_addr = a; host_wdata = w; host_size = sz;
    @(negedge clk);
    rd = host_rdata; er = host_err;
    host_req = 0; host_we = 0; host_wdata = 0;
  endtask

  task automatic respond(input logic [31:0] d, input bit e);
    bus_ack = 1; bus_rdata = d; bus_err = e;
    @(negedge clk);
    bus_ack = 0; bus_rdata = 0; bus_err = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 req in reset", {63'h0, bus_req}, 64'h0);
    rst_n = 1; run = 1;
    @(negedge clk);
    chk("R10 ack idle", {63'h0, host_ack}, 64'h0);
    host(0, 5'h10, 0); chk("R10 status zero", rd, 64'h0);
    host(0, 5'h18, 0); chk("R10 data zero", rd, 64'h0);

    host(1, 5'h18, 64'hDEADBEEF_12345678);
    host(0, 5'h18, 0); chk("R7 data readback", rd, 64'hDEADBEEF_00000000);
    host(0, 5'h00, 0); chk("R8 ctl reads zero", rd, 64'h0);
    host(0, 5'h08, 0); chk("R8 rst reads zero", rd, 64'h0);
    host(1, 5'h08, '1);
    host(1, 5'h10, '1);
    host(0, 5'h10, 0); chk("R8 status write ignored", rd, 64'h0);
    host(1, 5'h18, 64'h11111111_00000000, 4'd4);
    chk("R1 short size err", {63'h0, er}, 64'h1);
    host(1, 5'h1C, 64'h22222222_00000000);
    chk("R1 misaligned err", {63'h0, er}, 64'h1);
    host(0, 5'h18, 0); chk("R1 data unchanged", rd, 64'hDEADBEEF_00000000);

    // internal write, error on bus must not show in status
    host(1, 5'h00, {4'h0, 4'h4, 8'h00, 16'h0000, 32'h0000_1000});
    chk("R2 req raised", {63'h0, bus_req}, 64'h1);
    chk("R5 wdata order", {32'h0, bus_wdata}, 64'hDEADBEEF);
    host(1, 5'h18, 64'h55555555_00000000);
    chk("R5 wdata snapshot", {32'h0, bus_wdata}, 64'hDEADBEEF);
    host(0, 5'h10, 0); chk("R9 pending status zero", rd, 64'h0);
    host(1, 5'h00, {16'h0001, 16'h0, 32'h0000_2222});
    chk("R9 relaunch ignored", {32'h0, bus_addr}, 64'h1000);
    @(negedge clk);
    respond(32'h0, 1'b1);
    host(0, 5'h10, 0); chk("R5 write done only", rd, 64'h800);
    host(0, 5'h10, 0); chk("R6 cleared on read", rd, 64'h0);

    // successful read
    host(1, 5'h00, {4'h0, 4'h4, 8'h01, 16'h0000, 32'h0000_0020});
    chk("R2 read dir", {63'h0, bus_we}, 64'h0);
    repeat (2) @(negedge clk);
    respond(32'hA1B2C3D4, 1'b0);
    host(1, 5'h10, 64'h0);
    host(0, 5'h10, 0);
    chk("R3 read status", rd, 64'h800 | (64'hA1B2C3D4 << 26));

    // failed read
    host(1, 5'h00, {4'h0, 4'h1, 8'h01, 16'h0000, 32'hCAFE_0000});
    respond(32'h12345678, 1'b1);
    host(0, 5'h10, 0);
    chk("R4 read error status", rd, 64'h800 | (64'hFFFFFFFF << 26));
    host(0, 5'h10, 0); chk("R6 second read zero", rd, 64'h0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule